// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block walks a chain of 16-byte scatter-gather descriptors held in memory and turns each one into a single transfer command for a separate data mover. A command is started with a packet base address and the packet's register-area length field. The first descriptor sits right after that register area, at base + (length field + 2) × 8. The walker fetches each descriptor one 32-bit word at a time through a simple memory read port.

Each descriptor is laid out as four little-endian 32-bit words:
- word 0 is the buffer address;
- word 1 is the length in 8-byte units;
- word 2 holds a flags byte in bits 7:0 and a mode byte in bits 15:8, and the remaining bytes are ignored;
- word 3 is the address of the next descriptor.

For each descriptor the walker presents the command and holds it until the data mover reports completion. It then follows the next pointer, unless the descriptor was flagged as the last one. At the end it gives a one-cycle done pulse. An error flag reports a misaligned base, a misaligned buffer address, or a broken link.

Top module: `prd_walk`

## Requirements
- R1: After reset, busy, done, err, rdReq and xferValid are all low.
- R2: A walk accepted by `start` reads the first descriptor at cmdBase + (cmdLen + 2) × 8. Each descriptor's words are read in order at offsets 0, 4, 8 and 12, one word per read handshake (rdReq high until rdValid), and rdAddr stays stable while a read waits.
- R3: Each transfer command drives its outputs from the descriptor as follows:
  - xferAddr is word 0;
  - xferBytes is word 1 shifted left by 3;
  - xferOrdered is word 2 bit 4;
  - xferOut is word 2 bit 5;
  - xferLast is word 2 bit 7;
  - xferMode is word 2 bits 11:8. Bits 15:12 of word 2 (the upper half of the mode byte) and bits 31:16 are ignored.
- R4: A transfer command stays valid and stable until xferDone; no memory read is issued while a command is pending, and the next descriptor is fetched only after completion.
- R5: For a descriptor without the last flag, the walk continues at its word-3 pointer, so transfers come out in chain order.
- R6: For a descriptor with the last flag (word 2 bit 7), word 3 is never read and its value has no effect. done is a one-cycle pulse in the cycle after the final xferDone.
- R7: If cmdBase bits 2:0 are not zero, the walk ends with done and err in the cycle after start, with no read and no transfer.
- R8: If a descriptor's buffer address has bits 2:0 not zero, the walk ends after that descriptor's words are read, with err set and no transfer for it.
- R9: If a descriptor without the last flag has a next pointer that is zero or has bits 2:0 not zero, the walk ends with err set and no transfer for that descriptor.
- R10: err rises only together with done, stays high while idle, and clears when the next start is accepted. A walk without faults leaves err low.
- R11: start has no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken only when idle) |
| cmdBase | input | ADDR_W | Command packet base address |
| cmdLen | input | CLEN_W | Register-area length field of the packet |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Fault seen in the last walk |
| rdReq | output | 1 | Memory word read request |
| rdAddr | output | ADDR_W | Byte address of the requested word |
| rdValid | input | 1 | Read data returned this cycle |
| rdData | input | 32 | Returned little-endian word |
| xferValid | output | 1 | Transfer command pending |
| xferAddr | output | ADDR_W | Buffer address |
| xferBytes | output | LEN_W+3 | Transfer length in bytes |
| xferOut | output | 1 | Outbound (toward disk) direction |
| xferOrdered | output | 1 | Ordering flag |
| xferMode | output | 4 | Transfer mode for this entry |
| xferLast | output | 1 | Entry is the last of the chain |
| xferDone | input | 1 | Data mover finished the command |

## Verification
The properties assume that rdValid is raised only while rdReq is high, with one return per requested word. They also assume that xferDone is raised only while xferValid is high. The bench's memory model answers a request only when it sees rdReq, and drops rdValid again at the next falling edge. Its data-mover model answers only a pending command, in the same way. Latencies are swept from zero to two cycles for both, so back-to-back answers and waiting periods both occur within these rules.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;

  localparam int WORD_W    = 32;
  localparam int UNIT_LOG2 = 3;   // 8-byte units and alignment
  localparam int IDX_W     = 2;
  localparam int MODE_W    = 4;

  localparam logic [IDX_W-1:0] W_BUF  = 2'd0;
  localparam logic [IDX_W-1:0] W_LEN  = 2'd1;
  localparam logic [IDX_W-1:0] W_CTL  = 2'd2;
  localparam logic [IDX_W-1:0] W_LINK = 2'd3;

  localparam int FLAG_ORD  = 4;
  localparam int FLAG_OUT  = 5;
  localparam int FLAG_LAST = 7;
  localparam int MODE_LSB  = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_FIN
  } walkState_t;

  typedef struct packed {
    logic loadBase;
    logic takeWord;
    logic loadLink;
  } walkCtl_t;

  typedef struct packed {
    logic baseBad;
    logic entryEnd;
    logic entryBad;
    logic lastEntry;
  } walkStat_t;

endpackage

// File: rtl/prd_walk_dp.sv
module prd_walk_dp
  import prd_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int CLEN_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  walkCtl_t                    ctl,
  input  logic [ADDR_W-1:0]           cmdBase,
  input  logic [CLEN_W-1:0]           cmdLen,
  input  logic [WORD_W-1:0]           rdData,
  output walkStat_t                   stat,
  output logic [ADDR_W-1:0]           rdAddr,
  output logic [ADDR_W-1:0]           xferAddr,
  output logic [LEN_W+UNIT_LOG2-1:0]  xferBytes,
  output logic                        xferOut,
  output logic                        xferOrdered,
  output logic                        xferLast,
  output logic [MODE_W-1:0]           xferMode
);

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] firstPtr;
  logic [ADDR_W-1:0] bufAddr;
  logic [ADDR_W-1:0] nextPtr;
  logic [LEN_W-1:0]  lenUnits;
  logic [IDX_W-1:0]  idx;
  logic [MODE_W-1:0] mode;
  logic              ordF;
  logic              outF;
  logic              lastF;
  logic              linkBad;

  // first descriptor follows the register pairs of the packet
  assign firstPtr = cmdBase + ((ADDR_W'(cmdLen) + ADDR_W'(2)) << UNIT_LOG2);
  assign rdAddr   = ptr + ADDR_W'({idx, 2'b00});

  assign linkBad = (rdData[ADDR_W-1:0] == '0) || (|rdData[UNIT_LOG2-1:0]);

  always_comb begin
    stat           = '0;
    stat.baseBad   = |cmdBase[UNIT_LOG2-1:0];
    stat.entryEnd  = (idx == W_LINK) || ((idx == W_CTL) && rdData[FLAG_LAST]);
    stat.entryBad  = (|bufAddr[UNIT_LOG2-1:0]) || ((idx == W_LINK) && linkBad);
    stat.lastEntry = lastF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      idx <= '0;
    end else begin
      if (ctl.loadBase) begin
        ptr <= firstPtr;
        idx <= '0;
      end else begin
        if (ctl.loadLink) ptr <= nextPtr;
        if (ctl.takeWord) idx <= stat.entryEnd ? '0 : idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr  <= '0;
      lenUnits <= '0;
      ordF     <= 1'b0;
      outF     <= 1'b0;
      lastF    <= 1'b0;
      mode     <= '0;
      nextPtr  <= '0;
    end else if (ctl.takeWord) begin
      case (idx)
        W_BUF:  bufAddr  <= rdData[ADDR_W-1:0];
        W_LEN:  lenUnits <= rdData[LEN_W-1:0];
        W_CTL: begin
          ordF  <= rdData[FLAG_ORD];
          outF  <= rdData[FLAG_OUT];
          lastF <= rdData[FLAG_LAST];
          mode  <= rdData[MODE_LSB +: MODE_W];
        end
        default: nextPtr <= rdData[ADDR_W-1:0];
      endcase
    end
  end

  assign xferAddr    = bufAddr;
  assign xferBytes   = {lenUnits, {UNIT_LOG2{1'b0}}};
  assign xferOut     = outF;
  assign xferOrdered = ordF;
  assign xferLast    = lastF;
  assign xferMode    = mode;

endmodule

// File: rtl/prd_walk_ctrl.sv
module prd_walk_ctrl
  import prd_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      rdValid,
  input  logic      xferDone,
  input  walkStat_t stat,
  output walkCtl_t  ctl,
  output logic      rdReq,
  output logic      xferValid,
  output logic      done,
  output logic      busy,
  output logic      err
);

  walkState_t st, stNext;
  logic       errNext;

  always_comb begin
    stNext  = st;
    errNext = err;
    ctl     = '0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          ctl.loadBase = 1'b1;
          errNext      = stat.baseBad;
          stNext       = stat.baseBad ? ST_FIN : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (rdValid) begin
          ctl.takeWord = 1'b1;
          if (stat.entryEnd) begin
            if (stat.entryBad) begin
              errNext = 1'b1;
              stNext  = ST_FIN;
            end else begin
              stNext = ST_XFER;
            end
          end
        end
      end
      ST_XFER: begin
        if (xferDone) begin
          if (stat.lastEntry) begin
            stNext = ST_FIN;
          end else begin
            ctl.loadLink = 1'b1;
            stNext       = ST_FETCH;
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      err <= 1'b0;
    end else begin
      st  <= stNext;
      err <= errNext;
    end
  end

  assign rdReq     = (st == ST_FETCH);
  assign xferValid = (st == ST_XFER);
  assign done      = (st == ST_FIN);
  assign busy      = (st != ST_IDLE);

endmodule

// File: rtl/prd_walk.sv
module prd_walk
  import prd_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int CLEN_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           cmdBase,
  input  logic [CLEN_W-1:0]           cmdLen,
  output logic                        busy,
  output logic                        done,
  output logic                        err,
  output logic                        rdReq,
  output logic [ADDR_W-1:0]           rdAddr,
  input  logic                        rdValid,
  input  logic [31:0]                 rdData,
  output logic                        xferValid,
  output logic [ADDR_W-1:0]           xferAddr,
  output logic [LEN_W+UNIT_LOG2-1:0]  xferBytes,
  output logic                        xferOut,
  output logic                        xferOrdered,
  output logic [MODE_W-1:0]           xferMode,
  output logic                        xferLast,
  input  logic                        xferDone
);

  walkCtl_t  ctl;
  walkStat_t stat;

  prd_walk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .rdValid   (rdValid),
    .xferDone  (xferDone),
    .stat      (stat),
    .ctl       (ctl),
    .rdReq     (rdReq),
    .xferValid (xferValid),
    .done      (done),
    .busy      (busy),
    .err       (err)
  );

  prd_walk_dp #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CLEN_W (CLEN_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cmdBase     (cmdBase),
    .cmdLen      (cmdLen),
    .rdData      (rdData),
    .stat        (stat),
    .rdAddr      (rdAddr),
    .xferAddr    (xferAddr),
    .xferBytes   (xferBytes),
    .xferOut     (xferOut),
    .xferOrdered (xferOrdered),
    .xferLast    (xferLast),
    .xferMode    (xferMode)
  );

endmodule

// File: rtl/prd_walk_chk.sv
module prd_walk_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              xferValid,
  input logic [ADDR_W-1:0] xferAddr,
  input logic [LEN_W+2:0]  xferBytes,
  input logic              xferDone
);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdValid |=> rdReq && $stable(rdAddr));

  // R2
  rd_word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> rdAddr[1:0] == 2'b00);

  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferValid && !xferDone |=> xferValid && $stable(xferAddr) && $stable(xferBytes));

  // R4
  no_read_in_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && xferValid));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy && !rdReq && !xferValid);

  // R8
  xfer_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> xferAddr[2:0] == 3'b000);

  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done);

  // R10
  err_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && err && !$past(done) |-> $stable(err) || busy);

endmodule

bind prd_walk prd_walk_chk #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .rdReq     (rdReq),
  .rdAddr    (rdAddr),
  .rdValid   (rdValid),
  .xferValid (xferValid),
  .xferAddr  (xferAddr),
  .xferBytes (xferBytes),
  .xferDone  (xferDone)
);

// File: tb/tb_prd_walk.sv
module tb_prd_walk;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cmdBase = '0;
  logic [7:0]  cmdLen = '0;
  logic        busy, done, err, rdReq, xferValid;
  logic [31:0] rdAddr, xferAddr;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic [34:0] xferBytes;
  logic        xferOut, xferOrdered, xferLast;
  logic [3:0]  xferMode;
  logic        xferDone = 1'b0;

  prd_walk dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdBase(cmdBase), .cmdLen(cmdLen),
    .busy(busy), .done(done), .err(err), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .xferValid(xferValid), .xferAddr(xferAddr),
    .xferBytes(xferBytes), .xferOut(xferOut), .xferOrdered(xferOrdered),
    .xferMode(xferMode), .xferLast(xferLast), .xferDone(xferDone)
  );

  logic [31:0] mem [256];

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  int          expN, expRdN, gotN, gotRdN, overlap;
  logic [31:0] expA [16];
  logic [34:0] expB [16];
  logic [6:0]  expF [16];
  logic [31:0] expRd [64];
  logic [31:0] gotA [16];
  logic [34:0] gotB [16];
  logic [6:0]  gotF [16];
  logic [31:0] gotRd [64];
  bit          sawDone;
  int          doneCyc, lastXCyc;
  logic        errAtStart;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    expN = 0;
    expRdN = 0;
  endtask

  task automatic putEntry(input logic [31:0] a, input logic [31:0] bufA,
                          input logic [31:0] lenU, input logic [7:0] flg,
                          input logic [3:0] md, input logic [31:0] nxt,
                          input bit expectXfer);
    mem[a[9:2]]        = bufA;
    mem[a[9:2] + 8'd1] = lenU;
    mem[a[9:2] + 8'd2] = {8'h5A, 8'hC3, 4'h9, md, flg};
    mem[a[9:2] + 8'd3] = nxt;
    expRd[expRdN] = a;        expRdN++;
    expRd[expRdN] = a + 4;    expRdN++;
    expRd[expRdN] = a + 8;    expRdN++;
    if (!flg[7]) begin
      expRd[expRdN] = a + 12; expRdN++;
    end
    if (expectXfer) begin
      expA[expN] = bufA;
      expB[expN] = {lenU, 3'b000};
      expF[expN] = {flg[5], flg[4], flg[7], md};
      expN++;
    end
  endtask

  task automatic runWalk(input logic [31:0] base, input logic [7:0] clen,
                         input int latR, input int latX, input bit midStart);
    int cyc;
    int rdW;
    int xW;
    gotN = 0; gotRdN = 0; overlap = 0;
    rdW = latR; xW = latX;
    sawDone = 0; doneCyc = -1; lastXCyc = -100;
    @(negedge clk);
    cmdBase = base; cmdLen = clen; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!sawDone && cyc < 600) begin
      if (cyc == 0) errAtStart = err;
      if (midStart && cyc == 2) begin start = 1'b1; cmdBase = base | 32'h3; end
      else if (midStart && cyc == 3) start = 1'b0;
      if (rdReq && xferValid) overlap++;
      if (rdReq) begin
        if (rdW == 0) begin
          rdValid = 1'b1;
          rdData  = mem[rdAddr[9:2]];
          if (gotRdN < 64) gotRd[gotRdN] = rdAddr;
          gotRdN++;
          rdW = latR;
        end else begin
          rdValid = 1'b0;
          rdW--;
        end
      end else begin
        rdValid = 1'b0;
      end
      if (xferValid) begin
        if (xW == 0) begin
          xferDone = 1'b1;
          if (gotN < 16) begin
            gotA[gotN] = xferAddr;
            gotB[gotN] = xferBytes;
            gotF[gotN] = {xferOut, xferOrdered, xferLast, xferMode};
          end
          gotN++;
          lastXCyc = cyc;
          xW = latX;
        end else begin
          xferDone = 1'b0;
          xW--;
        end
      end else begin
        xferDone = 1'b0;
      end
      if (done) begin
        sawDone = 1;
        doneCyc = cyc;
      end
      @(negedge clk);
      cyc++;
    end
    rdValid = 1'b0;
    xferDone = 1'b0;
    check(sawDone, "R6", "walk reached done", 64'(sawDone), 64'd1);
    check(!done, "R6", "done is one cycle wide", 64'(done), 64'd0);
  endtask

  task automatic compareWalk();
    check(gotN == expN, "R5", "transfer count", 64'(gotN), 64'(expN));
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotA[i] == expA[i], "R3", "buffer address", 64'(gotA[i]), 64'(expA[i]));
      check(gotB[i] == expB[i], "R3", "byte count", 64'(gotB[i]), 64'(expB[i]));
      check(gotF[i] == expF[i], "R3", "out/ord/last/mode", 64'(gotF[i]), 64'(expF[i]));
    end
    check(gotRdN == expRdN, "R2", "read count", 64'(gotRdN), 64'(expRdN));
    for (int i = 0; i < expRdN && i < gotRdN; i++)
      check(gotRd[i] == expRd[i], "R2", "read address", 64'(gotRd[i]), 64'(expRd[i]));
    check(overlap == 0, "R4", "read during pending transfer", 64'(overlap), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] first, a, bufA, lenU, nxt;
    logic [7:0]  flg;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, err, rdReq, xferValid} == 5'b0, "R1", "outputs in reset",
          64'({busy, done, err, rdReq, xferValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, err, rdReq, xferValid} == 5'b0, "R1", "outputs after reset",
          64'({busy, done, err, rdReq, xferValid}), 64'd0);

    // Sweep chain length, packet length field and handshake latencies
    for (int n = 1; n <= 4; n++) begin
      for (int clen = 0; clen < 4; clen++) begin
        for (int lat = 0; lat < 3; lat++) begin
          clearAll();
          first = 32'h40 + 32'((clen + 2) * 8);
          for (int k = 0; k < n; k++) begin
            a    = (k == 0) ? first : 32'h200 + 32'(k * 32);
            bufA = 32'h10000 * 32'(k + 1) + 32'(8 * (clen + lat));
            lenU = 32'(k * 5 + clen + lat + 1);
            flg  = (((k + lat) % 2) == 1 ? 8'h20 : 8'h00) | (k == 1 ? 8'h10 : 8'h00) |
                   (k == n - 1 ? 8'h80 : 8'h00) | 8'h01;
            if (k == n - 1) nxt = (lat == 2) ? 32'h3F3 : 32'h0;   // R6 junk link
            else            nxt = 32'h200 + 32'((k + 1) * 32);
            putEntry(a, bufA, lenU, flg, 4'((k * 3 + clen) & 15), nxt, 1'b1);
          end
          runWalk(32'h40, 8'(clen), lat, 2 - lat, (n == 2 && lat == 1));
          compareWalk();
          check(!err, "R10", "err low after clean walk", 64'(err), 64'd0);
          check(doneCyc == lastXCyc + 1, "R6", "done cycle after final completion",
                64'(doneCyc), 64'(lastXCyc + 1));
          if (n == 2 && lat == 1)
            check(gotN == expN && !err, "R11", "start while busy ignored",
                  64'(gotN), 64'(expN));
        end
      end
    end

    // R7 misaligned packet base
    clearAll();
    runWalk(32'h44, 8'd1, 0, 0, 1'b0);
    compareWalk();
    check(err, "R7", "err on misaligned base", 64'(err), 64'd1);
    check(doneCyc == 0, "R7", "done right after start", 64'(doneCyc), 64'd0);

    // R8 misaligned buffer address in the middle of a chain
    clearAll();
    putEntry(32'h50, 32'h3000, 32'd4, 8'h20, 4'h2, 32'h300, 1'b1);
    putEntry(32'h300, 32'h2004, 32'd2, 8'h00, 4'h1, 32'h340, 1'b0);
    runWalk(32'h40, 8'd0, 1, 1, 1'b0);
    compareWalk();
    check(err, "R8", "err on misaligned buffer", 64'(err), 64'd1);

    // R8 misaligned buffer on the last entry
    clearAll();
    putEntry(32'h50, 32'h4001, 32'd3, 8'h80, 4'h5, 32'h0, 1'b0);
    runWalk(32'h40, 8'd0, 0, 0, 1'b0);
    compareWalk();
    check(err, "R8", "err on misaligned last buffer", 64'(err), 64'd1);

    // R9 zero link on a non-last entry
    clearAll();
    putEntry(32'h58, 32'h5000, 32'd1, 8'h10, 4'h3, 32'h380, 1'b1);
    putEntry(32'h380, 32'h5800, 32'd7, 8'h00, 4'h4, 32'h0, 1'b0);
    runWalk(32'h40, 8'd1, 2, 0, 1'b0);
    compareWalk();
    check(err, "R9", "err on zero link", 64'(err), 64'd1);

    // R9 misaligned link on the first entry
    clearAll();
    putEntry(32'h60, 32'h6000, 32'd9, 8'h30, 4'h6, 32'h204, 1'b0);
    runWalk(32'h40, 8'd2, 0, 1, 1'b0);
    compareWalk();
    check(err, "R9", "err on misaligned link", 64'(err), 64'd1);

    // R10 err held while idle, cleared by the next start
    repeat (5) @(negedge clk);
    check(err && !busy, "R10", "err held while idle", 64'({err, busy}), 64'b10);
    clearAll();
    putEntry(32'h50, 32'h7000, 32'd2, 8'h80, 4'h7, 32'h0, 1'b1);
    runWalk(32'h40, 8'd0, 1, 1, 1'b0);
    compareWalk();
    check(errAtStart == 1'b0, "R10", "err cleared by start", 64'(errAtStart), 64'd0);
    check(!err, "R10", "err low after recovery walk", 64'(err), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule